// File: doc/BRIEF.md
# CAN-over-Ethernet Tunnel Encapsulator

The encapsulator gathers received CAN and CAN-FD messages and packs them into tunnel Ethernet frames. Messages that arrive one after another with the same stream number are bunched into one frame. Each frame starts with a fixed 42-byte header. The header carries the MAC addresses, a VLAN tag, the tunnel ethertype, a per-stream sequence number, a stream identifier, the timestamp of the first message and the total payload length. One sub-record per message follows the header. A sub-record holds the message's own type, length, flags, source bus, capture time, identifier and data.

Messages are held in a small store until the frame closes, because the header has to state the payload length before any sub-record goes out. A frame closes in four cases:
- the next message would push the payload past a configured limit;
- the next message belongs to a different stream;
- the store is full;
- a flush request arrives.

The frame then leaves as a byte stream, one byte per clock, with start and end markers. MAC, FCS and decapsulation are handled elsewhere. The block assumes that `in_len` never exceeds `MAX_DATA` and that `max_payload` is at least the size of one largest sub-record.

Top module: `cantun_encap`

## Requirements
- R1: Each frame begins with a 42-byte header. Multi-byte fields are sent most significant byte first. The header layout is:
  - bytes 0-5: `dst_mac`
  - bytes 6-11: `src_mac`
  - bytes 12-13: 0x8100
  - bytes 14-15: `vlan_tci`
  - bytes 16-17: 0x22F0
  - byte 18: parameter `SUBTYPE` (default 0x05)
  - byte 19: 0x80
  - byte 20: sequence number
  - byte 21: 0x00
  - bytes 22-29: stream ID, made of `src_mac`, then 0x00, then `{2'b00, stream}`
  - bytes 30-37: timestamp, as seconds then nanoseconds
  - bytes 38-39: payload length
  - bytes 40-41: 0x0000
- R2: Each message becomes one sub-record. Multi-byte fields are sent most significant byte first. The layout is:
  - byte 0: 0x01 (CAN type)
  - byte 1: data length
  - byte 2: flags
  - byte 3: `{5'b0, bus}`
  - bytes 4-7: seconds
  - bytes 8-11: nanoseconds
  - bytes 12-15: `{3'b0, id}`
  - then the data bytes, with data byte k taken from `in_data[8k+7:8k]`
  - then zero bytes up to a multiple of 4, so the sub-record length is 16 + roundup4(len)
- R3: The payload length field equals the sum of the sub-record lengths, and the frame is exactly 42 + that many bytes long.
- R4: Each of the `STREAMS` streams has its own 8-bit sequence number. It is 0 after reset, increases by one for each frame sent on that stream, and wraps from 255 to 0.
- R5: Consecutive messages of one stream share a frame, in arrival order.
- R6: If accepting a message would make the payload exceed `max_payload`, the open frame is sent first. The message then starts the next frame. A payload exactly equal to `max_payload` is allowed.
- R7: A message whose stream differs from the open frame's stream closes that frame and starts a new one.
- R8: While `flush` is high, `in_ready` is low. `flush` sends a non-empty frame. `flush` with no stored message produces no frame.
- R9: A frame holding `MAX_MSGS` messages is sent without waiting for further input.
- R10: The output stream behaves as follows:
  - `out_sof` marks the first byte of a frame and `out_eof` marks the last.
  - Bytes of one frame come on consecutive cycles.
  - At least one idle cycle separates frames.
  - `in_ready` stays low while a frame is being emitted.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.
- R12: The header timestamp is the capture time of the first message in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| max_payload | input | 16 | Largest payload length allowed in one frame |
| dst_mac | input | 48 | Destination MAC address |
| src_mac | input | 48 | Source MAC address; also the upper part of the stream ID |
| vlan_tci | input | 16 | VLAN tag control word |
| flush | input | 1 | Close and send the open frame |
| in_valid | input | 1 | Message present |
| in_ready | output | 1 | Message accepted on this edge when high together with `in_valid` |
| in_stream | input | log2(STREAMS) | Tunnel stream of the message |
| in_id | input | 29 | CAN identifier |
| in_len | input | 7 | Data length in bytes |
| in_flags | input | 8 | Message flags |
| in_bus | input | 3 | Source CAN bus number |
| in_sec | input | 32 | Capture time, seconds |
| in_nsec | input | 32 | Capture time, nanoseconds |
| in_data | input | MAX_DATA*8 | Data, byte 0 in the low bits |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |

## Verification
The sequence wrap of a single stream is the hardest behaviour to reach from the ports, because it needs 256 completed frames on that stream. The stimulus sends 257 one-message frames on one stream, each closed by a flush. Two other cases need precise timing:
- A flush raised in the same cycle as a valid message is reached by asserting both on one cycle.
- The exact-limit payload is reached with a 64-byte message followed by a 1-byte message, which fills the frame to exactly 100 bytes.

The bench keeps its own model of the frame packing and compares every received frame byte by byte.

// File: rtl/cantun_pkg.sv
// Shared constants, the message descriptor type and the sub-record length rule.
package cantun_pkg;
    localparam int          HDR_BYTES    = 42;
    localparam int          REC_FIXED    = 16;
    localparam logic [7:0]  REC_TYPE_CAN = 8'h01;
    localparam logic [15:0] TPID_VLAN    = 16'h8100;
    localparam logic [15:0] ETYPE_TUNNEL = 16'h22F0;
    localparam logic [7:0]  HDR_VERSION  = 8'h80;

    typedef struct packed {
        logic [28:0] id;
        logic [6:0]  dlen;
        logic [7:0]  flags;
        logic [2:0]  bus;
        logic [31:0] sec;
        logic [31:0] nsec;
    } msg_meta_t;

    // Sub-record length: fixed part plus data rounded up to 4 bytes.
    function automatic logic [7:0] rec_len(input logic [6:0] dlen);
        logic [7:0] rounded;
        rounded = {1'b0, dlen} + 8'd3;
        return 8'(REC_FIXED) + {rounded[7:2], 2'b00};
    endfunction
endpackage

// File: rtl/cantun_seq_table.sv
// Per-stream sequence counters.
// Assumes: only one stream is bumped per cycle; the counters wrap naturally.
module cantun_seq_table #(
    parameter int STREAMS = 64,
    parameter int SEQ_W   = 8,
    localparam int SW     = $clog2(STREAMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    rd_sel,
    output logic [SEQ_W-1:0] rd_seq,
    input  logic             bump,
    input  logic [SW-1:0]    bump_sel
);
    logic [SEQ_W-1:0] seq_q [STREAMS];

    // Read the counter of the selected stream.
    assign rd_seq = seq_q[rd_sel];

    // Clear on reset; advance the counter of the stream whose frame completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STREAMS; i++) seq_q[i] <= '0;
        end else if (bump) begin
            seq_q[bump_sel] <= seq_q[bump_sel] + 1'b1;
        end
    end
endmodule

// File: rtl/cantun_msg_store.sv
// Holds the messages of the open frame, with the running payload length and stream.
// Assumes: wr_en is only raised while count < MAX_MSGS; clear wins over wr_en.
module cantun_msg_store
    import cantun_pkg::*;
#(
    parameter int MAX_MSGS = 8,
    parameter int MAX_DATA = 64,
    parameter int SW       = 6,
    localparam int IDX_W   = $clog2(MAX_MSGS),
    localparam int CNT_W   = $clog2(MAX_MSGS + 1),
    localparam int DW      = MAX_DATA * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             clear,
    input  logic [SW-1:0]    wr_stream,
    input  msg_meta_t        wr_meta,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output msg_meta_t        rd_meta,
    output logic [DW-1:0]    rd_data,
    output msg_meta_t        first_meta,
    output logic [CNT_W-1:0] count,
    output logic [15:0]      pay_len,
    output logic [SW-1:0]    frame_stream
);
    msg_meta_t         meta_q [MAX_MSGS];
    logic [DW-1:0]     data_q [MAX_MSGS];
    logic [IDX_W-1:0]  wr_idx;

    assign wr_idx = count[IDX_W-1:0];

    // Read ports for the emitter.
    assign rd_meta    = meta_q[rd_idx];
    assign rd_data    = data_q[rd_idx];
    assign first_meta = meta_q[0];

    // Store message contents; no reset needed, guarded by count.
    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            meta_q[wr_idx] <= wr_meta;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Track message count, payload length and the stream of the open frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count        <= '0;
            pay_len      <= '0;
            frame_stream <= '0;
        end else if (clear) begin
            count   <= '0;
            pay_len <= '0;
        end else if (wr_en) begin
            count   <= count + 1'b1;
            pay_len <= pay_len + {8'd0, rec_len(wr_meta.dlen)};
            if (count == '0) frame_stream <= wr_stream;
        end
    end
endmodule

// File: rtl/cantun_emit.sv
// Serialises one frame: the 42-byte header, then every stored sub-record, one byte per cycle.
// Assumes: frame inputs stay stable from start until done; pay_len > 0.
module cantun_emit
    import cantun_pkg::*;
#(
    parameter int MAX_MSGS      = 8,
    parameter int MAX_DATA      = 64,
    parameter int SW            = 6,
    parameter logic [7:0] SUBTYPE = 8'h05,
    localparam int IDX_W        = $clog2(MAX_MSGS),
    localparam int DW           = MAX_DATA * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [47:0]      dst_mac,
    input  logic [47:0]      src_mac,
    input  logic [15:0]      vlan_tci,
    input  logic [7:0]       seq,
    input  logic [SW-1:0]    stream,
    input  logic [15:0]      pay_len,
    input  msg_meta_t        first_meta,
    input  msg_meta_t        rd_meta,
    input  logic [DW-1:0]    rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             done,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof
);
    logic        active;
    logic [15:0] bcnt;
    logic [7:0]  roff;
    logic [15:0] last_pos;
    logic [7:0]  cur_len;
    logic [7:0]  hdr_byte;
    logic [7:0]  rec_byte;
    logic [31:0] vlan_word;
    logic [63:0] stream_id;
    logic [63:0] ts_word;
    logic [31:0] id_word;

    assign last_pos  = 16'(HDR_BYTES) + pay_len - 16'd1;
    assign cur_len   = rec_len(rd_meta.dlen);
    assign done      = active && (bcnt == last_pos);
    assign vlan_word = {TPID_VLAN, vlan_tci};
    assign stream_id = {src_mac, 8'h00, 8'(stream)};
    assign ts_word   = {first_meta.sec, first_meta.nsec};
    assign id_word   = {3'b000, rd_meta.id};

    // Select the header byte at the current position.
    always_comb begin : p_hdr
        int h;
        h = int'(bcnt);
        hdr_byte = 8'h00;
        if (h < 6)        hdr_byte = dst_mac[47 - 8*h -: 8];
        else if (h < 12)  hdr_byte = src_mac[47 - 8*(h-6) -: 8];
        else if (h < 16)  hdr_byte = vlan_word[31 - 8*(h-12) -: 8];
        else if (h < 18)  hdr_byte = ETYPE_TUNNEL[15 - 8*(h-16) -: 8];
        else if (h == 18) hdr_byte = SUBTYPE;
        else if (h == 19) hdr_byte = HDR_VERSION;
        else if (h == 20) hdr_byte = seq;
        else if (h == 21) hdr_byte = 8'h00;
        else if (h < 30)  hdr_byte = stream_id[63 - 8*(h-22) -: 8];
        else if (h < 38)  hdr_byte = ts_word[63 - 8*(h-30) -: 8];
        else if (h < 40)  hdr_byte = pay_len[15 - 8*(h-38) -: 8];
    end

    // Select the sub-record byte at the current offset, zero in the padding.
    always_comb begin : p_rec
        int r;
        int k;
        r = int'(roff);
        k = r - REC_FIXED;
        rec_byte = 8'h00;
        if (r == 0)       rec_byte = REC_TYPE_CAN;
        else if (r == 1)  rec_byte = {1'b0, rd_meta.dlen};
        else if (r == 2)  rec_byte = rd_meta.flags;
        else if (r == 3)  rec_byte = {5'b00000, rd_meta.bus};
        else if (r < 8)   rec_byte = rd_meta.sec[31 - 8*(r-4) -: 8];
        else if (r < 12)  rec_byte = rd_meta.nsec[31 - 8*(r-8) -: 8];
        else if (r < 16)  rec_byte = id_word[31 - 8*(r-12) -: 8];
        else if (k < MAX_DATA && k < int'(rd_meta.dlen)) rec_byte = rd_data[8*k +: 8];
    end

    // Walk the frame positions: header bytes, then record index and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            bcnt   <= '0;
            roff   <= '0;
            rd_idx <= '0;
        end else if (start) begin
            active <= 1'b1;
            bcnt   <= '0;
            roff   <= '0;
            rd_idx <= '0;
        end else if (active) begin
            if (done) begin
                active <= 1'b0;
            end else begin
                bcnt <= bcnt + 16'd1;
                if (bcnt >= 16'(HDR_BYTES)) begin
                    if (roff == cur_len - 8'd1) begin
                        roff   <= '0;
                        rd_idx <= rd_idx + 1'b1;
                    end else begin
                        roff <= roff + 8'd1;
                    end
                end
            end
        end
    end

    // Register the output byte and its frame markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
        end else begin
            out_valid <= active;
            out_data  <= (bcnt < 16'(HDR_BYTES)) ? hdr_byte : rec_byte;
            out_sof   <= active && (bcnt == 16'd0);
            out_eof   <= done;
        end
    end
endmodule

// File: rtl/cantun_encap.sv
// Top of the tunnel encapsulator: accepts messages, decides when a frame closes,
// drives the emitter and the per-stream sequence counters.
// Assumes: in_len <= MAX_DATA; max_payload holds at least one largest sub-record.
module cantun_encap
    import cantun_pkg::*;
#(
    parameter int STREAMS         = 64,
    parameter int MAX_MSGS        = 8,
    parameter int MAX_DATA        = 64,
    parameter logic [7:0] SUBTYPE = 8'h05,
    localparam int SW             = $clog2(STREAMS),
    localparam int IDX_W          = $clog2(MAX_MSGS),
    localparam int CNT_W          = $clog2(MAX_MSGS + 1),
    localparam int DW             = MAX_DATA * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       max_payload,
    input  logic [47:0]       dst_mac,
    input  logic [47:0]       src_mac,
    input  logic [15:0]       vlan_tci,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SW-1:0]     in_stream,
    input  logic [28:0]       in_id,
    input  logic [6:0]        in_len,
    input  logic [7:0]        in_flags,
    input  logic [2:0]        in_bus,
    input  logic [31:0]       in_sec,
    input  logic [31:0]       in_nsec,
    input  logic [DW-1:0]     in_data,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof
);
    logic             sending_q;
    logic             close_now;
    logic             accept;
    logic             emit_done;
    logic [CNT_W-1:0] msg_count;
    logic [15:0]      pay_len;
    logic [15:0]      next_len;
    logic [SW-1:0]    frame_stream;
    logic [7:0]       cur_seq;
    logic [IDX_W-1:0] rd_idx;
    msg_meta_t        wr_meta;
    msg_meta_t        rd_meta;
    msg_meta_t        first_meta;
    logic [DW-1:0]    rd_data;

    // Pack the incoming message fields.
    always_comb begin
        wr_meta.id    = in_id;
        wr_meta.dlen  = in_len;
        wr_meta.flags = in_flags;
        wr_meta.bus   = in_bus;
        wr_meta.sec   = in_sec;
        wr_meta.nsec  = in_nsec;
    end

    // Close decision: flush, full store, stream change or payload limit.
    assign next_len  = pay_len + {8'd0, rec_len(in_len)};
    assign close_now = !sending_q && (msg_count != '0) &&
                       (flush || (msg_count == CNT_W'(MAX_MSGS)) ||
                        (in_valid && ((in_stream != frame_stream) || (next_len > max_payload))));
    assign in_ready  = !sending_q && !flush && !close_now;
    assign accept    = in_valid && in_ready;

    // Collect/send state.
    always_ff @(posedge clk) begin
        if (!rst_n)         sending_q <= 1'b0;
        else if (close_now) sending_q <= 1'b1;
        else if (emit_done) sending_q <= 1'b0;
    end

    cantun_msg_store #(
        .MAX_MSGS(MAX_MSGS), .MAX_DATA(MAX_DATA), .SW(SW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .clear(emit_done),
        .wr_stream(in_stream), .wr_meta(wr_meta), .wr_data(in_data),
        .rd_idx(rd_idx), .rd_meta(rd_meta), .rd_data(rd_data),
        .first_meta(first_meta), .count(msg_count), .pay_len(pay_len),
        .frame_stream(frame_stream)
    );

    cantun_seq_table #(
        .STREAMS(STREAMS), .SEQ_W(8)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .rd_sel(frame_stream), .rd_seq(cur_seq),
        .bump(emit_done), .bump_sel(frame_stream)
    );

    cantun_emit #(
        .MAX_MSGS(MAX_MSGS), .MAX_DATA(MAX_DATA), .SW(SW), .SUBTYPE(SUBTYPE)
    ) u_emit (
        .clk(clk), .rst_n(rst_n), .start(close_now),
        .dst_mac(dst_mac), .src_mac(src_mac), .vlan_tci(vlan_tci),
        .seq(cur_seq), .stream(frame_stream), .pay_len(pay_len),
        .first_meta(first_meta), .rd_meta(rd_meta), .rd_data(rd_data),
        .rd_idx(rd_idx), .done(emit_done),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof)
    );
endmodule

// File: rtl/cantun_encap_chk.sv
// Property checker for cantun_encap, attached by bind below.
// Assumes: it sees the top's ports and the store's message count.
module cantun_encap_chk #(
    parameter int MAX_MSGS = 8,
    localparam int CNT_W   = $clog2(MAX_MSGS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic [CNT_W-1:0] msg_count
);
    // R10: a frame's first byte carries the start marker.
    p_sof_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sof);
    // R10: markers only appear on valid bytes.
    p_marks_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> out_valid);
    // R10: bytes of a frame are back to back.
    p_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eof) |=> out_valid);
    // R10: an idle cycle follows every frame end.
    p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_valid);
    // R10: no message is accepted mid-frame.
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eof) |-> !in_ready);
    // R8: flush blocks acceptance.
    p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !in_ready);
    // R9: the store never holds more than its capacity.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_count <= CNT_W'(MAX_MSGS));
    // R9: a full store accepts nothing more.
    p_full_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_count == CNT_W'(MAX_MSGS)) |-> !in_ready);
endmodule

bind cantun_encap cantun_encap_chk #(.MAX_MSGS(MAX_MSGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_ready(in_ready),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .msg_count(msg_count)
);

// File: tb/tb_cantun_encap.sv
module tb_cantun_encap;
    localparam int MAXD = 64;
    localparam int MAXM = 8;
    localparam logic [47:0] DMAC = 48'h02_11_22_33_44_55;
    localparam logic [47:0] SMAC = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [15:0] TCI  = 16'hA00B;
    // Vector fields: [31] flush after, [30:25] stream, [24:18] length, [17:0] id
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 6'd3, 7'd8,  18'h00123},
        {1'b0, 6'd3, 7'd5,  18'h00456},
        {1'b0, 6'd3, 7'd13, 18'h1ABCD},
        {1'b0, 6'd3, 7'd8,  18'h00777},   // exceeds 100: closes first frame (R6)
        {1'b1, 6'd3, 7'd0,  18'h00010},
        {1'b0, 6'd7, 7'd64, 18'h3FFFF},
        {1'b0, 6'd7, 7'd1,  18'h00042},   // payload exactly 100 (R6)
        {1'b0, 6'd9, 7'd2,  18'h00100},   // stream change (R7)
        {1'b1, 6'd9, 7'd8,  18'h00200}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] max_payload = 16'd100;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [5:0] in_stream = '0;
    logic [28:0] in_id = '0;
    logic [6:0] in_len = '0;
    logic [7:0] in_flags = '0;
    logic [2:0] in_bus = '0;
    logic [31:0] in_sec = '0;
    logic [31:0] in_nsec = '0;
    logic [MAXD*8-1:0] in_data = '0;
    logic out_valid, out_sof, out_eof;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    cantun_encap dut (
        .clk(clk), .rst_n(rst_n), .max_payload(max_payload), .dst_mac(DMAC),
        .src_mac(SMAC), .vlan_tci(TCI), .flush(flush), .in_valid(in_valid),
        .in_ready(in_ready), .in_stream(in_stream), .in_id(in_id), .in_len(in_len),
        .in_flags(in_flags), .in_bus(in_bus), .in_sec(in_sec), .in_nsec(in_nsec),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Bench model state
    logic [7:0] exp_b [16][512];
    int exp_len [16];
    int e_cnt = 0;
    logic [7:0] seq_m [64];
    int m_cnt = 0;
    int m_acc = 0;
    logic [5:0] m_stream = '0;
    int mm_idx [MAXM];
    logic [6:0] mm_len [MAXM];
    logic [28:0] mm_id [MAXM];

    function automatic logic [31:0] f_sec(input int i);  return 32'h1000_0000 + 32'(i); endfunction
    function automatic logic [31:0] f_ns(input int i);   return 32'h0A00_0000 + 32'(i * 3); endfunction
    function automatic logic [7:0]  f_flg(input int i);  return 8'(i) ^ 8'h5A; endfunction
    function automatic logic [2:0]  f_bus(input int i);  return 3'(i % 8); endfunction
    function automatic logic [7:0]  f_dat(input int i, input int k); return 8'(i * 7 + k); endfunction
    function automatic int rlen(input logic [6:0] l); return 16 + ((int'(l) + 3) / 4) * 4; endfunction

    task automatic put_b(input int e, inout int p, input logic [7:0] b);
        exp_b[e][p] = b;
        p++;
    endtask

    task automatic put_w(input int e, inout int p, input logic [63:0] w, input int nb);
        for (int i = nb - 1; i >= 0; i--) put_b(e, p, w[8*i +: 8]);
    endtask

    // Build the expected frame from the requirements (R1, R2, R3, R12).
    task automatic model_close();
        int e;
        int p;
        e = e_cnt % 16;
        p = 0;
        put_w(e, p, 64'(DMAC), 6);
        put_w(e, p, 64'(SMAC), 6);
        put_w(e, p, 64'h8100, 2);
        put_w(e, p, 64'(TCI), 2);
        put_w(e, p, 64'h22F0, 2);
        put_b(e, p, 8'h05);
        put_b(e, p, 8'h80);
        put_b(e, p, seq_m[m_stream]);
        put_b(e, p, 8'h00);
        put_w(e, p, 64'(SMAC), 6);
        put_b(e, p, 8'h00);
        put_b(e, p, {2'b00, m_stream});
        put_w(e, p, 64'(f_sec(mm_idx[0])), 4);
        put_w(e, p, 64'(f_ns(mm_idx[0])), 4);
        put_w(e, p, 64'(m_acc), 2);
        put_w(e, p, 64'h0, 2);
        for (int m = 0; m < m_cnt; m++) begin
            put_b(e, p, 8'h01);
            put_b(e, p, {1'b0, mm_len[m]});
            put_b(e, p, f_flg(mm_idx[m]));
            put_b(e, p, {5'b0, f_bus(mm_idx[m])});
            put_w(e, p, 64'(f_sec(mm_idx[m])), 4);
            put_w(e, p, 64'(f_ns(mm_idx[m])), 4);
            put_w(e, p, 64'({3'b000, mm_id[m]}), 4);
            for (int k = 0; k < rlen(mm_len[m]) - 16; k++)
                put_b(e, p, (k < int'(mm_len[m])) ? f_dat(mm_idx[m], k) : 8'h00);
        end
        exp_len[e] = p;
        e_cnt++;
        seq_m[m_stream] = seq_m[m_stream] + 8'd1;
        m_cnt = 0;
        m_acc = 0;
    endtask

    // Frame monitor: collects bytes and compares each frame to the model.
    logic [7:0] cur [1024];
    int cur_n = 0;
    bit in_frame = 0;
    int rx_cnt = 0;
    int last_len = 0;
    logic [7:0] last_seq = '0;
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_sof) begin
                if (in_frame) begin
                    checks++; fails++;
                    $display("FAIL R10 start marker inside frame: got sof=1 exp 0");
                end
                cur_n = 0;
                in_frame = 1;
            end else if (!in_frame) begin
                checks++; fails++;
                $display("FAIL R10 byte outside frame: got sof=0 exp 1");
            end
            if (cur_n < 1024) cur[cur_n] = out_data;
            cur_n++;
            if (out_eof) begin
                int e;
                int diff;
                e = rx_cnt % 16;
                diff = -1;
                checks++;
                if (rx_cnt >= e_cnt) begin
                    fails++;
                    $display("FAIL R5/R6/R7 unexpected frame %0d: got %0d frames exp %0d", rx_cnt, rx_cnt + 1, e_cnt);
                end else begin
                    for (int i = 0; i < exp_len[e] && i < cur_n; i++)
                        if (diff < 0 && cur[i] !== exp_b[e][i]) diff = i;
                    if (cur_n != exp_len[e] || diff >= 0) begin
                        fails++;
                        $display("FAIL R1/R2/R3/R5/R12 frame %0d: len got %0d exp %0d, byte %0d got %h exp %h",
                                 rx_cnt, cur_n, exp_len[e], diff,
                                 (diff >= 0) ? cur[diff] : 8'h00, (diff >= 0) ? exp_b[e][diff] : 8'h00);
                    end
                end
                last_len = cur_n;
                last_seq = cur[20];
                rx_cnt++;
                in_frame = 0;
            end
        end
    end

    task automatic wait_ready();
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
    endtask

    task automatic send_msg(input int idx, input logic [5:0] s, input logic [6:0] len,
                            input logic [17:0] id, input bit with_flush);
        int rl;
        rl = rlen(len);
        @(negedge clk);
        if (with_flush) wait_ready();
        if (with_flush && m_cnt > 0) model_close();
        if (m_cnt > 0 && (s != m_stream || m_acc + rl > int'(max_payload))) model_close();
        if (m_cnt == 0) m_stream = s;
        mm_idx[m_cnt] = idx;
        mm_len[m_cnt] = len;
        mm_id[m_cnt]  = 29'(id);
        m_acc += rl;
        m_cnt++;
        if (m_cnt == MAXM) model_close();
        in_stream = s; in_len = len; in_id = 29'(id);
        in_flags = f_flg(idx); in_bus = f_bus(idx);
        in_sec = f_sec(idx); in_nsec = f_ns(idx);
        for (int k = 0; k < MAXD; k++) in_data[8*k +: 8] = f_dat(idx, k);
        in_valid = 1'b1;
        flush = with_flush;
        if (with_flush) begin
            #1;
            checks++;
            if (in_ready !== 1'b0) begin
                fails++;
                $display("FAIL R8 ready during flush: got %b exp 0", in_ready);
            end
            @(negedge clk);
            flush = 1'b0;
        end
        wait_ready();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        wait_ready();
        flush = 1'b1;
        if (m_cnt > 0) model_close();
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic check_eq(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired: got timeout exp completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int rx0;
        for (int i = 0; i < 64; i++) seq_m[i] = 8'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: reset state
        check_eq("R11 in_ready after reset", int'(in_ready), 1);
        check_eq("R11 out_valid after reset", int'(out_valid), 0);

        // Table walk: bunching, limit, exact limit, stream change (R5, R6, R7)
        for (int v = 0; v < NV; v++) begin
            send_msg(v, VEC[v][30:25], VEC[v][24:18], VEC[v][17:0], 1'b0);
            if (VEC[v][31]) do_flush();
        end
        repeat (300) @(negedge clk);
        check_eq("R6/R7 frames from table", rx_cnt, 4);

        // R8: flush with nothing stored produces no frame
        rx0 = rx_cnt;
        do_flush();
        repeat (20) @(negedge clk);
        check_eq("R8 empty flush frame count", rx_cnt, rx0);
        #1;
        check_eq("R8 ready after empty flush", int'(in_ready), 1);

        // R9: full store closes itself under a large limit
        max_payload = 16'd1000;
        for (int i = 0; i < MAXM; i++) send_msg(100 + i, 6'd5, 7'd0, 18'(i + 1), 1'b0);
        repeat (250) @(negedge clk);
        check_eq("R9 auto close frame count", rx_cnt, rx0 + 1);
        check_eq("R9 auto close frame length", last_len, 42 + 16 * MAXM);

        // R8: flush together with a valid message
        send_msg(200, 6'd6, 7'd4, 18'h00AA, 1'b0);
        send_msg(201, 6'd6, 7'd4, 18'h00BB, 1'b1);
        do_flush();
        repeat (150) @(negedge clk);
        check_eq("R8 flush with valid frame count", rx_cnt, rx0 + 3);

        // R4: sequence wrap on one stream after 256 frames
        for (int i = 0; i < 257; i++) begin
            send_msg(300 + i, 6'd1, 7'd0, 18'h00001, 1'b0);
            do_flush();
        end
        repeat (150) @(negedge clk);
        check_eq("R4 frames on wrap stream", rx_cnt, rx0 + 3 + 257);
        check_eq("R4 sequence after wrap", int'(last_seq), 0);
        check_eq("R5 all model frames received", rx_cnt, e_cnt);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule